// File: doc/BRIEF.md
# Vector Extended-Divide Unit

This unit performs extended division on 128-bit vector operands. In an extended divide, each element of the first operand is moved into the upper half of a value twice its width, and the lower half is filled with zeros. That double-width value is divided by the matching element of the second operand. The result is the low element-sized part of the quotient.

Four operations are selected by an 11-bit extended opcode:

- signed doubleword and unsigned doubleword, where the two 64-bit lanes are worked on independently and at the same time;
- signed quadword and unsigned quadword, where the whole 128-bit operand is a single element.

Two cases give back the first operand's element unchanged: a zero divisor, and, in signed modes only, the most negative value divided by minus one.

The unit is a radix-2 restoring shift-subtract divider. It works on magnitudes and produces one quotient bit per clock. A caller asserts `start` for one cycle with the operands and opcode applied. It then waits for the one-cycle `done` pulse. The result stays on `res` until the next accepted start.

Top module: `vdive_unit`

## Requirements
- R1: In doubleword modes, lane 0 is bits [63:0] and lane 1 is bits [127:64]. Each lane's result depends only on that lane's operand elements.
- R2: For unsigned modes, each result element is the low element-width bits of (A_element × 2^width) / B_element.
- R3: For signed modes, the quotient of (A_element × 2^width) / B_element is truncated toward zero. Its low element-width bits, in two's complement, form the result.
- R4: A zero divisor element returns the A element unchanged, in both signed and unsigned modes.
- R5: In signed modes, an A element equal to the most negative value combined with a divisor element of all ones returns the A element unchanged.
- R6: Quadword mode treats the full 128-bit operands as one element and follows the same rules, with 2^127 as the most negative value.
- R7: The extended opcodes are 01111001011 (signed doubleword), 01011001011 (unsigned doubleword), 01100001011 (signed quadword) and 01000001011 (unsigned quadword). A start with any other code is ignored: no done pulse follows, and the result does not change.
- R8: If start is accepted at clock edge 0, done is high after edge 128 in doubleword modes and after edge 256 in quadword modes.
- R9: A start that arrives while a division is running is ignored. It does not change that division's result or its timing.
- R10: done stays high for exactly one cycle. res stays unchanged from then until the next accepted start.
- R11: When a quotient is too wide for the element, its low bits are returned and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an operation when the unit is idle |
| xop | input | 11 | Extended opcode that selects the operation |
| opa | input | 128 | Dividend operand A |
| opb | input | 128 | Divisor operand B |
| res | output | 128 | Result |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The properties assume that `start` is a synchronous level, sampled at each edge, and that the operands and opcode only matter in the cycle where a start is accepted. The bench therefore changes inputs only at falling edges and lowers `start` one cycle after it raises it. On purpose, the stimulus also raises `start` in the middle of a division and with an undefined opcode, so the ignore paths are exercised under the assumptions the properties make.

// File: rtl/vdive_unit.sv
module vdive_unit #(
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [10:0]     xop,
  input  logic [2*DW-1:0] opa,
  input  logic [2*DW-1:0] opb,
  output logic [2*DW-1:0] res,
  output logic            done
);
  localparam int QW = 2 * DW;
  localparam int CW = $clog2(2 * QW) + 1;

  localparam logic [10:0] OP_SD = 11'b01111001011;
  localparam logic [10:0] OP_UD = 11'b01011001011;
  localparam logic [10:0] OP_SQ = 11'b01100001011;
  localparam logic [10:0] OP_UQ = 11'b01000001011;

  logic          busy, quad, sgn;
  logic [CW-1:0] cnt;
  logic [QW-1:0] lres [3];

  wire op_ok   = (xop == OP_SD) | (xop == OP_UD) | (xop == OP_SQ) | (xop == OP_UQ);
  wire accept  = start & ~busy & op_ok;
  wire sel_q   = (xop == OP_SQ) | (xop == OP_UQ);
  wire sel_s   = (xop == OP_SD) | (xop == OP_SQ);
  wire last    = busy & (cnt == (quad ? CW'(2*QW-1) : CW'(2*DW-1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      quad <= 1'b0;
      sgn  <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
        quad <= sel_q;
        sgn  <= sel_s;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_lane
    localparam int LW  = (g == 2) ? QW : DW;
    localparam int OFF = (g == 2) ? 0 : g * DW;

    wire [LW-1:0] ae = opa[OFF +: LW];
    wire [LW-1:0] be = opb[OFF +: LW];
    wire          an = sel_s & ae[LW-1];
    wire          bn = sel_s & be[LW-1];
    wire          ovf = sel_s & (ae == {1'b1, {(LW-1){1'b0}}}) & (&be);

    logic [LW-1:0]   aq, dm, rem, quo;
    logic [2*LW-1:0] num;
    logic            spec, neg;

    wire [LW:0] t    = {rem, num[2*LW-1]};
    wire        ge   = t >= {1'b0, dm};
    wire [LW:0] diff = t - {1'b0, dm};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        aq <= '0; dm <= '0; rem <= '0; quo <= '0; num <= '0;
        spec <= 1'b0; neg <= 1'b0;
      end else if (accept) begin
        aq   <= ae;
        dm   <= bn ? -be : be;
        num  <= {(an ? -ae : ae), {LW{1'b0}}};
        rem  <= '0;
        quo  <= '0;
        spec <= (be == '0) | ovf;
        neg  <= an ^ bn;
      end else if (busy) begin
        rem <= ge ? diff[LW-1:0] : t[LW-1:0];
        num <= num << 1;
        quo <= {quo[LW-2:0], ge};
      end
    end

    wire [LW-1:0] lv = spec ? aq : (neg ? -quo : quo);
    assign lres[g] = QW'(lv);
  end

  assign res = quad ? lres[2] : {lres[1][DW-1:0], lres[0][DW-1:0]};
endmodule

module vdive_unit_chk #(
  parameter int RW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          op_ok,
  input logic          done,
  input logic [RW-1:0] res
);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(res));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  p_bad_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !op_ok) |=> (!busy && !done && $stable(res)));

  p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

bind vdive_unit vdive_unit_chk #(.RW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .op_ok(op_ok), .done(done), .res(res)
);

// File: tb/vdive_unit_bench.sv
module vdive_unit_bench;
  localparam logic [10:0] SD = 11'b01111001011;
  localparam logic [10:0] UD = 11'b01011001011;
  localparam logic [10:0] SQ = 11'b01100001011;
  localparam logic [10:0] UQ = 11'b01000001011;
  localparam int NV = 15;

  localparam logic [394:0] VEC [NV] = '{
    {UD, 64'h1, 64'h3, 64'h2, 64'h4, 64'h8000000000000000, 64'hC000000000000000},
    {UD, 64'h5, 64'h1, 64'h1, 64'h3, 64'h0, 64'h5555555555555555},
    {SD, 64'hFFFFFFFFFFFFFFFF, 64'h1, 64'h2, 64'hFFFFFFFFFFFFFFFE,
         64'h8000000000000000, 64'h8000000000000000},
    {SD, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h3, 64'hFFFFFFFFFFFFFFFD,
         64'hAAAAAAAAAAAAAAAB, 64'h5555555555555555},
    {UD, 64'h1234, 64'hFFFF0000FFFF0000, 64'h0, 64'h0, 64'h1234, 64'hFFFF0000FFFF0000},
    {SD, 64'h8000000000000001, 64'h1, 64'h0, 64'h3, 64'h8000000000000001, 64'h5555555555555555},
    {SD, 64'h8000000000000000, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'h2,
         64'h8000000000000000, 64'h0},
    {UD, 64'h8000000000000000, 64'h0, 64'h2, 64'h5, 64'h0, 64'h0},
    {UQ, 128'h1, 128'h2, 128'h80000000000000000000000000000000},
    {UQ, 128'h1, 128'h3, 128'h55555555555555555555555555555555},
    {SQ, {128{1'b1}}, 128'h3, 128'hAAAAAAAAAAAAAAAAAAAAAAAAAAAAAAAB},
    {SQ, 128'h80000000000000000000000000000000, {128{1'b1}},
         128'h80000000000000000000000000000000},
    {UQ, 128'h1234, 128'h0, 128'h1234},
    {UD, 128'h1, 128'h2, 64'h0, 64'h8000000000000000},
    {SQ, 128'h1, {{127{1'b1}}, 1'b0}, 128'h80000000000000000000000000000000}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [10:0]  xop = '0;
  logic [127:0] opa = '0, opb = '0, res;
  logic done;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  vdive_unit u_vdive_unit (.clk(clk), .rst_n(rst_n), .start(start), .xop(xop),
    .opa(opa), .opb(opb), .res(res), .done(done));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [10:0] op, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    xop = op; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [127:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && res == '0, "R10 reset state", {127'(0), done} | res, '0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0]  op = VEC[i][394:384];
      logic [127:0] a  = VEC[i][383:256];
      logic [127:0] b  = VEC[i][255:128];
      logic [127:0] e  = VEC[i][127:0];
      int el = (op == SQ || op == UQ) ? 256 : 128;
      launch(op, a, b);
      wait_done(lat);
      r = res;
      chk(r == e, "R1 R2 R3 R4 R5 R6 R11 vector result", r, e);
      chk(lat == el, "R8 latency", 128'(lat), 128'(el));
      @(negedge clk);
      chk(!done && res == r, "R10 one-cycle done and hold", res, r);
    end

    // R9: a second start mid-run is ignored
    launch(UD, {64'h1, 64'h3}, {64'h2, 64'h4});
    repeat (9) @(negedge clk);
    xop = UQ; opa = 128'h1; opb = 128'h3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk(res == {64'h8000000000000000, 64'hC000000000000000}, "R9 result unaffected", res,
        {64'h8000000000000000, 64'hC000000000000000});
    chk(lat + 10 == 128, "R9 timing unaffected", 128'(lat + 10), 128'd128);
    r = res;
    repeat (5) @(negedge clk);
    chk(res == r && !done, "R10 result holds while idle", res, r);

    // R7: undefined opcode is ignored
    launch(11'b01111001010, 128'h7, 128'h1);
    lat = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (done) lat++;
    end
    chk(lat == 0, "R7 no done for bad opcode", 128'(lat), 128'd0);
    chk(res == r, "R7 result unchanged for bad opcode", res, r);

    // R7: a valid code works afterwards
    launch(SD, {64'h0, 64'hFFFFFFFFFFFFFFFF}, {64'h5, 64'h3});
    wait_done(lat);
    chk(res == {64'h0, 64'hAAAAAAAAAAAAAAAB}, "R7 R3 signed doubleword after bad code", res,
        {64'h0, 64'hAAAAAAAAAAAAAAAB});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule